// File: doc/BRIEF.md
# Program-and-Verify Pulse Sequencer

This block drives the adaptive write algorithm for a one-time-programmable memory. After a start request it walks an address range upward. For each location it follows the same steps. It presents the address and captures the word to be written. It then gives a program pulse of fixed length and strobes a verify compare. If the compare fails, it gives another pulse. Once the compare passes, it applies one closing pulse. The length of that closing pulse is a multiple of the pulse time the location has already received. It then moves on.

An optional extra word, the initialization word, lies outside the normal address range. It is reached through a separate select output after the last normal address. The sequencer handles it with the same algorithm. If a location still fails after the last allowed attempt, the sequencer stops at once. It then reports a failure and the failing address.

The voltage switching and the memory array are outside the block. The surrounding logic turns `prog_pulse` into the programming stimulus. It answers `verify_stb` on `vfy_ok` in the same cycle, and it supplies the write data for the presented location on `src_data`.

Top module: `otp_pgm_seq`

## Requirements
- R1: While idle, a high `start` captures `first_addr`, `last_addr` and `incl_init`. The next cycle is a setup cycle that presents `first_addr` with `init_sel` low and both `prog_pulse` and `verify_stb` low. `start`, `first_addr`, `last_addr` and `incl_init` are ignored while a run is in progress.
- R2: Every program pulse holds `prog_pulse` high for exactly PULSE_CYC consecutive cycles, and the address is stable throughout.
- R3: The cycle right after each program pulse has `verify_stb` high for one cycle. `vfy_ok` is sampled in that cycle.
- R4: When `vfy_ok` is low at a verify and fewer than MAX_TRY pulses have been given to the location, the next program pulse starts in the following cycle.
- R5: When `vfy_ok` is high at a verify after k pulses, a closing pulse of MULT × k × PULSE_CYC cycles starts in the following cycle.
- R6: After the closing pulse of a location that is not the last, the next cycle is a setup cycle at the address plus one (modulo 2^ADDR_W). `pgm_data` takes the value of `src_data` during each setup cycle and holds it for the location.
- R7: With `incl_init` captured high, the location after `last_addr` is the initialization word. It is presented with `init_sel` high and `addr` held at `last_addr`. It goes through the same setup, pulse, verify and closing-pulse steps.
- R8: After the closing pulse of the final location, `done` is high for exactly one cycle. The block is then idle with no pulse or strobe.
- R9: A verify with `vfy_ok` low after MAX_TRY pulses stops the run. In the next cycle `fail` goes high and `fail_addr` holds the failing address, with `init_sel` showing whether it was the initialization word. No further pulse follows, and `fail` stays high until the next accepted `start` clears it.
- R10: During reset, `prog_pulse`, `verify_stb`, `done`, `fail`, `init_sel` and `addr` are all low.
- R11: `prog_pulse` and `verify_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run (honoured only when idle) |
| first_addr | input | ADDR_W | First location of the range |
| last_addr | input | ADDR_W | Last location of the range |
| incl_init | input | 1 | Also program the initialization word after the range |
| src_data | input | DATA_W | Write data for the presented location |
| vfy_ok | input | 1 | Compare result, valid while `verify_stb` is high |
| addr | output | ADDR_W | Presented location |
| init_sel | output | 1 | Selects the initialization word instead of `addr` |
| pgm_data | output | DATA_W | Word being written to the current location |
| prog_pulse | output | 1 | Program pulse active |
| verify_stb | output | 1 | Verify compare strobe |
| done | output | 1 | One-cycle pulse when a run finishes without a failure |
| fail | output | 1 | Run stopped on a location that would not verify |
| fail_addr | output | ADDR_W | Address at which the run stopped |

## Verification
An attempt counter that is off by one shows at the ports in one of two ways. Either a different number of PULSE_CYC-long bursts appears before the closing pulse, or `fail` rises one verify early or late. Either shows within one pulse length. A wrong pulse-time sum shows as a closing pulse that ends on the wrong cycle. A stepping error in the address logic shows on `addr` or `init_sel` at the very next setup cycle. The bench holds a per-cycle expectation of every output for the whole run, so any of these faults is reported in the cycle where it first appears.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_VERIFY,
    ST_EXTRA,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/otp_seq_timer.sv
// Loadable down-counter that marks the final cycle of a pulse window.
module otp_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          last
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = run && (cnt_q == TW'(1));

endmodule

// File: rtl/otp_seq_addr.sv
// Range stepper: walks first..last, then optionally the initialization word.
module otp_seq_addr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] first_in,
  input  logic [ADDR_W-1:0] last_in,
  input  logic              incl_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              init_sel,
  output logic              at_end
);

  logic [ADDR_W-1:0] addr_q, addr_d, end_q, end_d;
  logic              incl_q, incl_d, init_q, init_d;
  logic              on_last;

  assign on_last = (addr_q == end_q);

  always_comb begin
    addr_d = addr_q;
    end_d  = end_q;
    incl_d = incl_q;
    init_d = init_q;
    if (load) begin
      addr_d = first_in;
      end_d  = last_in;
      incl_d = incl_in;
      init_d = 1'b0;
    end else if (step) begin
      if (on_last && !init_q) begin
        init_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      end_q  <= '0;
      incl_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      end_q  <= end_d;
      incl_q <= incl_d;
      init_q <= init_d;
    end
  end

  assign addr     = addr_q;
  assign init_sel = init_q;
  assign at_end   = on_last && (!incl_q || init_q);

endmodule

// File: rtl/otp_pgm_seq.sv
module otp_pgm_seq #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 200000,
  parameter int MAX_TRY   = 5,
  parameter int MULT      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              incl_init,
  input  logic [DATA_W-1:0] src_data,
  input  logic              vfy_ok,
  output logic [ADDR_W-1:0] addr,
  output logic              init_sel,
  output logic [DATA_W-1:0] pgm_data,
  output logic              prog_pulse,
  output logic              verify_stb,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  import otp_seq_pkg::*;

  localparam int TW    = $clog2(MAX_TRY * PULSE_CYC * MULT + 1);
  localparam int TRY_W = $clog2(MAX_TRY + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  seq_state_t        state_q, state_d;
  logic [TRY_W-1:0]  tries_q, tries_d;
  logic [TW-1:0]     acc_q, acc_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;

  logic              tmr_load, tmr_last, tmr_run;
  logic [TW-1:0]     tmr_val;
  logic              ad_load, ad_step, ad_end;

  assign tmr_run = (state_q == ST_PULSE) || (state_q == ST_EXTRA);

  otp_seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .last     (tmr_last)
  );

  otp_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ad_load),
    .first_in (first_addr),
    .last_in  (last_addr),
    .incl_in  (incl_init),
    .step     (ad_step),
    .addr     (addr),
    .init_sel (init_sel),
    .at_end   (ad_end)
  );

  always_comb begin
    state_d  = state_q;
    tries_d  = tries_q;
    acc_d    = acc_q;
    data_d   = data_q;
    fail_d   = fail_q;
    faddr_d  = faddr_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(PULSE_CYC);
    ad_load  = 1'b0;
    ad_step  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          ad_load = 1'b1;
          fail_d  = 1'b0;
        end
      end
      ST_SETUP: begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tries_d  = '0;
        acc_d    = '0;
        data_d   = src_data;
      end
      ST_PULSE: begin
        if (tmr_last) begin
          state_d = ST_VERIFY;
          tries_d = tries_q + 1'b1;
          acc_d   = acc_q + TW'(PULSE_CYC);
        end
      end
      ST_VERIFY: begin
        if (vfy_ok) begin
          state_d  = ST_EXTRA;
          tmr_load = 1'b1;
          tmr_val  = TW'(MULT) * acc_q;
        end else if (tries_q == TRY_W'(MAX_TRY)) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          faddr_d = addr;
        end else begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
        end
      end
      ST_EXTRA: begin
        if (tmr_last) begin
          if (ad_end) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_SETUP;
            ad_step = 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      tries_q <= '0;
      acc_q   <= '0;
      data_q  <= '0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      tries_q <= tries_d;
      acc_q   <= acc_d;
      data_q  <= data_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
    end
  end

  assign prog_pulse = tmr_run;
  assign verify_stb = (state_q == ST_VERIFY);
  assign done       = (state_q == ST_DONE);
  assign fail       = fail_q;
  assign fail_addr  = faddr_q;
  assign pgm_data   = data_q;

endmodule

// File: rtl/otp_pgm_seq_chk.sv
module otp_pgm_seq_chk #(
  parameter int ADDR_W  = 4,
  parameter int TRY_W   = 3,
  parameter int MAX_TRY = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_pulse,
  input logic              verify_stb,
  input logic              vfy_ok,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] addr,
  input logic [TRY_W-1:0]  tries
);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_pulse && verify_stb));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  extra_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verify_stb && vfy_ok) |=> prog_pulse);

  // R9
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(verify_stb && !vfy_ok));

  // R4
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRY));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> $stable(addr));

  // R3
  verify_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verify_stb |-> $past(prog_pulse));

endmodule

bind otp_pgm_seq otp_pgm_seq_chk #(
  .ADDR_W  (ADDR_W),
  .TRY_W   (TRY_W),
  .MAX_TRY (MAX_TRY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog_pulse (prog_pulse),
  .verify_stb (verify_stb),
  .vfy_ok     (vfy_ok),
  .done       (done),
  .fail       (fail),
  .addr       (addr),
  .tries      (tries_q)
);

// File: tb/otp_pgm_seq_test.sv
`timescale 1ns/1ps
module otp_pgm_seq_test;

  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int PC   = 4;
  localparam int MAXT = 5;
  localparam int MUL  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] first_addr = '0;
  logic [AW-1:0] last_addr = '0;
  logic          incl_init = 1'b0;
  logic [DW-1:0] src_data;
  logic          vfy_ok;
  logic [AW-1:0] addr, fail_addr;
  logic          init_sel, prog_pulse, verify_stb, done, fail;
  logic [DW-1:0] pgm_data;

  always #2.5 clk = ~clk;

  otp_pgm_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .MAX_TRY(MAXT), .MULT(MUL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .incl_init(incl_init), .src_data(src_data),
    .vfy_ok(vfy_ok), .addr(addr), .init_sel(init_sel), .pgm_data(pgm_data),
    .prog_pulse(prog_pulse), .verify_stb(verify_stb), .done(done),
    .fail(fail), .fail_addr(fail_addr)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // memory model: pulses needed per location (index 16 = initialization word)
  int nd [0:16];
  int tally = 0;

  function automatic logic [DW-1:0] pat(input bit ini, input logic [AW-1:0] a);
    return ini ? 8'hA5 : ({a, a} ^ 8'h3C);
  endfunction

  assign src_data = pat(init_sel, addr);
  assign vfy_ok   = (tally >= nd[init_sel ? 16 : int'(addr)] * PC) &&
                    (pgm_data == pat(init_sel, addr));

  always @(posedge clk) begin
    if (!prog_pulse && !verify_stb) tally <= 0;
    else if (prog_pulse) tally <= tally + 1;
  end

  // expected per-cycle outputs: {done, init, vfy, prog, addr, data}
  typedef logic [15:0] ev_t;
  ev_t   eq[$];
  string tq[$];
  bit            idle_fail = 0;
  logic [AW-1:0] exp_faddr = '0;
  bit            exp_finit = 0;

  function automatic void put(bit dn, bit ini, bit v, bit p, logic [AW-1:0] a,
                              logic [DW-1:0] d, string t);
    eq.push_back({dn, ini, v, p, a, d});
    tq.push_back(t);
  endfunction

  task automatic plan(input int fa, input int la, input bit inc);
    int n;
    n = ((la - fa) & 15) + 1 + (inc ? 1 : 0);
    idle_fail = 0;
    for (int i = 0; i < n; i++) begin
      bit            ini;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int            need;
      int            k;
      bit            ok;
      ini  = inc && (i == n - 1);
      a    = ini ? AW'(la) : AW'(fa + i);
      d    = pat(ini, a);
      need = nd[ini ? 16 : int'(a)];
      k    = 0;
      ok   = 0;
      put(0, ini, 0, 0, a, d, (i == 0) ? "R1" : (ini ? "R7" : "R6"));
      while (!ok && k < MAXT) begin
        for (int c = 0; c < PC; c++) put(0, ini, 0, 1, a, d, (k == 0) ? "R2" : "R4");
        k++;
        ok = (k >= need);
        put(0, ini, 1, 0, a, d, "R3");
      end
      if (!ok) begin
        idle_fail = 1;
        exp_faddr = a;
        exp_finit = ini;
        return;
      end
      for (int c = 0; c < MUL * k * PC; c++) put(0, ini, 0, 1, a, d, "R5");
    end
    put(1, inc, 0, 0, AW'(la), pat(inc, AW'(la)), "R8");
  endtask

  task automatic chk(input string t, input string f, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, f, act, exp);
    end
  endtask

  // per-cycle comparison, just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !finished) begin
      if (eq.size() > 0) begin
        ev_t   e;
        string t;
        e = eq.pop_front();
        t = tq.pop_front();
        chk(t, "prog_pulse", int'(prog_pulse), int'(e[12]));
        chk(t, "verify_stb", int'(verify_stb), int'(e[13]));
        chk(t, "done", int'(done), int'(e[15]));
        chk(t, "init_sel", int'(init_sel), int'(e[14]));
        chk(t, "addr", int'(addr), int'(e[11:8]));
        chk("R9", "fail", int'(fail), 0);
        if (e[12] || e[13]) chk("R6", "pgm_data", int'(pgm_data), int'(e[7:0]));
      end else begin
        chk("R1", "idle prog_pulse", int'(prog_pulse), 0);
        chk("R1", "idle verify_stb", int'(verify_stb), 0);
        chk("R8", "idle done", int'(done), 0);
        chk("R9", "fail", int'(fail), int'(idle_fail));
        if (idle_fail) begin
          chk("R9", "fail_addr", int'(fail_addr), int'(exp_faddr));
          chk("R9", "init_sel", int'(init_sel), int'(exp_finit));
        end
      end
    end
  end

  task automatic launch(input int fa, input int la, input bit inc);
    @(negedge clk);
    first_addr = AW'(fa);
    last_addr  = AW'(la);
    incl_init  = inc;
    start      = 1'b1;
    plan(fa, la, inc);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    while (eq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i <= 16; i++) nd[i] = 1;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "prog_pulse", int'(prog_pulse), 0);
    chk("R10", "verify_stb", int'(verify_stb), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "fail", int'(fail), 0);
    chk("R10", "init_sel", int'(init_sel), 0);
    chk("R10", "addr", int'(addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // range with mixed attempt counts plus initialization word (R4 R5 R6 R7)
    nd[2] = 1; nd[3] = 2; nd[4] = 5; nd[5] = 3; nd[16] = 1;
    launch(2, 5, 1);
    // R1: start and range inputs during a run are ignored
    repeat (10) @(negedge clk);
    first_addr = 4'd0;
    last_addr  = 4'd15;
    incl_init  = 1'b0;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle();

    // single address, no initialization word
    nd[7] = 4;
    launch(7, 7, 0);
    settle();

    // R9: failure on a normal address
    nd[9] = 1; nd[10] = 6; nd[11] = 1;
    launch(9, 11, 0);
    settle();

    // restart clears fail
    nd[10] = 2; nd[16] = 2;
    launch(10, 10, 1);
    settle();

    // R9 with R7: failure on the initialization word
    nd[0] = 1; nd[1] = 1; nd[16] = 6;
    launch(0, 1, 1);
    settle();

    // wrapping range
    nd[15] = 1; nd[0] = 3;
    launch(15, 0, 0);
    settle();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule